// File: doc/BRIEF.md
# Flash Parameter Query Responder

This block models the query side of a parallel NOR flash command interface. It watches bus write cycles for command bytes and keeps track of which read mode the device is in: plain array read, identifier (autoselect) read, or parameter query. While in query mode, every read returns a fixed 16-bit word from an internal parameter table. The table covers the identification string, the primary command set, the system interface timing codes, the device geometry and the vendor extended fields.

The bus can address the table in two ways. In word mode each table entry has its own address. In byte mode each entry sits at twice its word address. The block remembers whether query mode was entered from array read or from identifier mode, so that the reset command returns to the correct mode. Array contents and identifier contents are modelled as fixed placeholder words. Read data is registered.

Top module: `cfi_query_unit`

## Requirements
- R1: After reset `mode` is 0 (array read) and `rdata` is 0000h.
- R2: Writing a low data byte of 98h enters query mode (`mode` = 2) from array read or identifier mode. In word mode the write must go to address 055h. In byte mode (`byte_mode` = 1) it must go to address 0AAh.
- R3: In array read mode, writing a low data byte of 90h to the same command address enters identifier mode (`mode` = 1).
- R4: Writing a low data byte of F0h to any address acts as the reset command. From query mode it returns to the mode that query was entered from. From identifier mode it returns to array read. In array read it leaves the mode at 0.
- R5: A write changes nothing in these cases: any other data byte, a command byte at a non-command address, or a 98h or 90h written while already in query mode.
- R6: A read strobe loads `rdata` on that clock edge, so the value is visible the following cycle. `rdata` holds its value until the next read strobe.
- R7: In array read mode, reads return ARRAY_FILL (default FFFFh). In identifier mode, reads return ID_WORD (default 0001h).
- R8: In query mode at word addresses 10h–1Ah, the block returns "QRY" (0051h, 0052h, 0059h). It then returns 0002h/0000h for the primary command set, 0040h/0000h for the extended table address, and zeros for the alternate set.
- R9: Word addresses 1Bh–26h return the interface codes. These are 0027h and 0036h for the supply range, 0004h at 1Fh for typical write (2^4 µs), and 000Ah at 21h for typical block erase (2^10 ms). The maximum write code is 0005h at 23h and the maximum erase code is 0004h at 25h. All other entries in this range are 0000h.
- R10: Word addresses 27h–4Ah return the geometry and extended fields, as follows:
  - size code 0016h at 27h and interface code 0002h at 28h
  - one erase region (0001h at 2Ch) described by 003Fh, 0000h, 0000h, 0001h at 2Dh–30h
  - "PRI" (0050h, 0052h, 0049h) at 40h–42h and version 0031h at 43h and 44h
  - 0002h at 46h, 0001h at 47h, 0001h at 48h, 0004h at 49h
  - 0000h at every other entry in this range
- R11: In word mode, a query read returns 0000h in two cases: any address bit from bit 7 upward is set, or the entry is not listed in R8–R10.
- R12: In byte mode, byte address 2·n returns the word-mode entry n. Odd byte addresses return 0000h, and so does any address with a bit set from bit 8 upward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | ADDR_W | Bus address (word or byte units) |
| wdata | input | DATA_W | Write data; command byte in bits 7:0 |
| byte_mode | input | 1 | 1 = byte addressing, 0 = word addressing |
| rdata | output | DATA_W | Registered read data |
| mode | output | 2 | 0 array read, 1 identifier, 2 query |

## Verification
A command write updates `mode` on the clock edge that samples `wr_en`, so the bench drives each write on a falling edge and compares `mode` one falling edge later. A read also takes effect on its sampling edge, so `rdata` is compared on the falling edge after the strobe is dropped. Any read's value therefore never depends on the ordering of events within an edge. The bench sweeps every address in both word and byte modes against a table it keeps itself, and it confirms that `rdata` stays unchanged across write-only cycles.

// File: rtl/cfi_pkg.sv
package cfi_pkg;
   typedef enum logic [1:0] {
      MODE_ARRAY = 2'd0,
      MODE_IDENT = 2'd1,
      MODE_QUERY = 2'd2
   } rd_mode_e;

   localparam logic [7:0] OP_QUERY = 8'h98;
   localparam logic [7:0] OP_IDENT = 8'h90;
   localparam logic [7:0] OP_RESET = 8'hF0;
   localparam logic [7:0] CMD_WORD_ADDR = 8'h55;
   localparam int unsigned TBL_IDX_W = 7;
endpackage

// File: rtl/cfi_addr_norm.sv
module cfi_addr_norm
   import cfi_pkg::*;
#(
   parameter int unsigned ADDR_W  = 12,
   parameter bit          BYTE_EN = 1'b1
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 byte_mode,
   output logic [TBL_IDX_W-1:0] idx,
   output logic                 in_window,
   output logic                 at_cmd
);
   localparam logic [ADDR_W-1:0] WCMD = ADDR_W'(CMD_WORD_ADDR);
   localparam logic [ADDR_W-1:0] BCMD = ADDR_W'({CMD_WORD_ADDR, 1'b0});

   logic [TBL_IDX_W-1:0] w_idx;
   logic                 w_win, w_cmd;

   always_comb begin
      w_idx = addr[TBL_IDX_W-1:0];
      w_win = (addr[ADDR_W-1:TBL_IDX_W] == '0);
      w_cmd = (addr == WCMD);
   end

   generate
      if (BYTE_EN) begin : g_dual
         logic [TBL_IDX_W-1:0] b_idx;
         logic                 b_win, b_cmd;
         always_comb begin
            b_idx = addr[TBL_IDX_W:1];
            b_win = (addr[ADDR_W-1:TBL_IDX_W+1] == '0) && !addr[0];
            b_cmd = (addr == BCMD);
            idx       = byte_mode ? b_idx : w_idx;
            in_window = byte_mode ? b_win : w_win;
            at_cmd    = byte_mode ? b_cmd : w_cmd;
         end
      end else begin : g_word
         always_comb begin
            idx       = w_idx;
            in_window = w_win;
            at_cmd    = w_cmd;
         end
      end
   endgenerate
endmodule

// File: rtl/cfi_mode_ctrl.sv
module cfi_mode_ctrl
   import cfi_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_en,
   input  logic [7:0] op,
   input  logic     at_cmd,
   output rd_mode_e cur_mode
);
   logic     from_ident;
   rd_mode_e nxt_mode;
   logic     nxt_from;

   always_comb begin
      nxt_mode = cur_mode;
      nxt_from = from_ident;
      if (wr_en) begin
         if (op == OP_RESET) begin
            unique case (cur_mode)
               MODE_QUERY: nxt_mode = from_ident ? MODE_IDENT : MODE_ARRAY;
               default:    nxt_mode = MODE_ARRAY;
            endcase
            nxt_from = 1'b0;
         end else if (op == OP_QUERY && at_cmd && cur_mode != MODE_QUERY) begin
            nxt_mode = MODE_QUERY;
            nxt_from = (cur_mode == MODE_IDENT);
         end else if (op == OP_IDENT && at_cmd && cur_mode == MODE_ARRAY) begin
            nxt_mode = MODE_IDENT;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_mode   <= MODE_ARRAY;
         from_ident <= 1'b0;
      end else begin
         cur_mode   <= nxt_mode;
         from_ident <= nxt_from;
      end
   end
endmodule

// File: rtl/cfi_param_rom.sv
module cfi_param_rom
   import cfi_pkg::*;
#(
   parameter int unsigned DATA_W     = 16,
   parameter logic [7:0]  SIZE_CODE  = 8'h16,
   parameter logic [7:0]  WR_TYP     = 8'h04,
   parameter logic [7:0]  ERASE_TYP  = 8'h0A,
   parameter logic [7:0]  WR_MAX     = 8'h05,
   parameter logic [7:0]  ERASE_MAX  = 8'h04
) (
   input  logic [TBL_IDX_W-1:0] idx,
   input  logic                 in_window,
   output logic [DATA_W-1:0]    value
);
   function automatic logic [7:0] entry(input logic [TBL_IDX_W-1:0] i);
      case (i)
         7'h10: entry = 8'h51;
         7'h11: entry = 8'h52;
         7'h12: entry = 8'h59;
         7'h13: entry = 8'h02;
         7'h15: entry = 8'h40;
         7'h1B: entry = 8'h27;
         7'h1C: entry = 8'h36;
         7'h1F: entry = WR_TYP;
         7'h21: entry = ERASE_TYP;
         7'h23: entry = WR_MAX;
         7'h25: entry = ERASE_MAX;
         7'h27: entry = SIZE_CODE;
         7'h28: entry = 8'h02;
         7'h2C: entry = 8'h01;
         7'h2D: entry = 8'h3F;
         7'h30: entry = 8'h01;
         7'h40: entry = 8'h50;
         7'h41: entry = 8'h52;
         7'h42: entry = 8'h49;
         7'h43: entry = 8'h31;
         7'h44: entry = 8'h31;
         7'h46: entry = 8'h02;
         7'h47: entry = 8'h01;
         7'h48: entry = 8'h01;
         7'h49: entry = 8'h04;
         default: entry = 8'h00;
      endcase
   endfunction

   always_comb begin
      value = '0;
      if (in_window) value[7:0] = entry(idx);
   end
endmodule

// File: rtl/cfi_query_unit.sv
module cfi_query_unit
   import cfi_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 16,
   parameter bit          BYTE_EN    = 1'b1,
   parameter logic [15:0] ARRAY_FILL = 16'hFFFF,
   parameter logic [15:0] ID_WORD    = 16'h0001,
   parameter logic [7:0]  SIZE_CODE  = 8'h16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              byte_mode,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        mode
);
   generate
      if (ADDR_W < 9) begin : g_bad_addr
         $error("cfi_query_unit: ADDR_W must be at least 9");
      end
      if (DATA_W < 16) begin : g_bad_data
         $error("cfi_query_unit: DATA_W must be at least 16");
      end
   endgenerate

   logic [TBL_IDX_W-1:0] idx;
   logic                 in_window, at_cmd;
   rd_mode_e             cur_mode;
   logic [DATA_W-1:0]    tbl_val;
   logic [DATA_W-1:0]    rd_next;

   cfi_addr_norm #(.ADDR_W(ADDR_W), .BYTE_EN(BYTE_EN)) u_norm (
      .addr(addr), .byte_mode(byte_mode),
      .idx(idx), .in_window(in_window), .at_cmd(at_cmd)
   );

   cfi_mode_ctrl u_mode (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .op(wdata[7:0]),
      .at_cmd(at_cmd), .cur_mode(cur_mode)
   );

   cfi_param_rom #(.DATA_W(DATA_W), .SIZE_CODE(SIZE_CODE)) u_rom (
      .idx(idx), .in_window(in_window), .value(tbl_val)
   );

   always_comb begin
      unique case (cur_mode)
         MODE_QUERY: rd_next = tbl_val;
         MODE_IDENT: rd_next = DATA_W'(ID_WORD);
         default:    rd_next = DATA_W'(ARRAY_FILL);
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_next;
   end

   assign mode = cur_mode;
endmodule

// File: rtl/cfi_query_unit_chk.sv
module cfi_query_unit_chk #(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 16,
   parameter logic [15:0] ARRAY_FILL = 16'hFFFF,
   parameter logic [15:0] ID_WORD    = 16'h0001
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              rd_en,
   input logic [ADDR_W-1:0] addr,
   input logic [DATA_W-1:0] wdata,
   input logic              byte_mode,
   input logic [DATA_W-1:0] rdata,
   input logic [1:0]        mode
);
   logic cmd_loc;
   assign cmd_loc = byte_mode ? (addr == ADDR_W'(9'h0AA)) : (addr == ADDR_W'(9'h055));

   p_mode_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'd3);

   p_mode_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(mode));

   p_query_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode == 2'd0 && wdata[7:0] == 8'h98 && cmd_loc) |=> mode == 2'd2);

   p_ident_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode == 2'd0 && wdata[7:0] == 8'h90 && cmd_loc) |=> mode == 2'd1);

   p_ident_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && mode == 2'd1 && wdata[7:0] == 8'hF0) |=> mode == 2'd0);

   p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   p_array_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == 2'd0) |=> rdata == DATA_W'(ARRAY_FILL));

   p_ident_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && mode == 2'd1) |=> rdata == DATA_W'(ID_WORD));
endmodule

bind cfi_query_unit cfi_query_unit_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ARRAY_FILL(ARRAY_FILL), .ID_WORD(ID_WORD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wdata(wdata), .byte_mode(byte_mode), .rdata(rdata), .mode(mode)
);

// File: tb/tb_cfi_query_unit.sv
module tb_cfi_query_unit;
   localparam int AW = 12;
   logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, byte_mode = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [15:0] wdata = '0, rdata;
   logic [1:0] mode;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   cfi_query_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .byte_mode(byte_mode), .rdata(rdata), .mode(mode)
   );

   function automatic logic [15:0] tbl(input int i);
      case (i)
         'h10: tbl = 16'h0051; 'h11: tbl = 16'h0052; 'h12: tbl = 16'h0059;
         'h13: tbl = 16'h0002; 'h15: tbl = 16'h0040;
         'h1B: tbl = 16'h0027; 'h1C: tbl = 16'h0036; 'h1F: tbl = 16'h0004;
         'h21: tbl = 16'h000A; 'h23: tbl = 16'h0005; 'h25: tbl = 16'h0004;
         'h27: tbl = 16'h0016; 'h28: tbl = 16'h0002; 'h2C: tbl = 16'h0001;
         'h2D: tbl = 16'h003F; 'h30: tbl = 16'h0001;
         'h40: tbl = 16'h0050; 'h41: tbl = 16'h0052; 'h42: tbl = 16'h0049;
         'h43: tbl = 16'h0031; 'h44: tbl = 16'h0031; 'h46: tbl = 16'h0002;
         'h47: tbl = 16'h0001; 'h48: tbl = 16'h0001; 'h49: tbl = 16'h0004;
         default: tbl = 16'h0000;
      endcase
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = {8'h00, d};
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : stim
      logic [15:0] held;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 mode", {14'd0, mode}, 16'd0);
      check("R1 rdata", rdata, 16'h0000);

      rd(12'h010);
      check("R7 array read", rdata, 16'hFFFF);
      repeat (3) @(negedge clk);
      check("R6 hold idle", rdata, 16'hFFFF);

      wr(12'h054, 8'h98); check("R5 query wrong addr", {14'd0, mode}, 16'd0);
      wr(12'h055, 8'h12); check("R5 other data", {14'd0, mode}, 16'd0);
      wr(12'h055, 8'h98); check("R2 query entry word", {14'd0, mode}, 16'd2);
      wr(12'h055, 8'h98); check("R5 query in query", {14'd0, mode}, 16'd2);
      wr(12'h055, 8'h90); check("R5 ident in query", {14'd0, mode}, 16'd2);

      for (int a = 0; a < (1 << AW); a++) begin
         logic [15:0] e;
         string tag;
         e = (a >> 7) != 0 ? 16'h0 : tbl(a & 'h7F);
         if (a >= 'h10 && a <= 'h1A) tag = "R8 word sweep";
         else if (a >= 'h1B && a <= 'h26) tag = "R9 word sweep";
         else if (a >= 'h27 && a <= 'h4A) tag = "R10 word sweep";
         else tag = "R11 word sweep";
         rd(AW'(a));
         if (rdata !== e) $display("  at word address %h", a);
         check(tag, rdata, e);
      end

      rd(12'h011); held = rdata;
      wr(12'h100, 8'h33);
      check("R6 hold across write", rdata, held);

      wr(12'h123, 8'hF0); check("R4 reset from query", {14'd0, mode}, 16'd0);

      byte_mode = 1'b1;
      wr(12'h055, 8'h98); check("R12 byte cmd at word addr", {14'd0, mode}, 16'd0);
      wr(12'h0AA, 8'h98); check("R2 query entry byte", {14'd0, mode}, 16'd2);
      for (int a = 0; a < (1 << AW); a++) begin
         logic [15:0] e;
         e = ((a >> 8) != 0 || (a & 1) != 0) ? 16'h0 : tbl((a >> 1) & 'h7F);
         rd(AW'(a));
         if (rdata !== e) $display("  at byte address %h", a);
         check("R12 byte sweep", rdata, e);
      end
      wr(12'h000, 8'hF0); check("R4 reset byte mode", {14'd0, mode}, 16'd0);
      byte_mode = 1'b0;

      wr(12'h055, 8'h90); check("R3 ident entry", {14'd0, mode}, 16'd1);
      rd(12'h000); check("R7 ident read", rdata, 16'h0001);
      wr(12'h055, 8'h98); check("R2 query from ident", {14'd0, mode}, 16'd2);
      rd(12'h012); check("R8 Y in query", rdata, 16'h0059);
      wr(12'h7FF, 8'hF0); check("R4 return to ident", {14'd0, mode}, 16'd1);
      wr(12'h001, 8'hF0); check("R4 ident to array", {14'd0, mode}, 16'd0);
      wr(12'h001, 8'hF0); check("R4 reset in array", {14'd0, mode}, 16'd0);
      wr(12'h055, 8'h98); wr(12'h002, 8'hF0);
      check("R4 query from array returns array", {14'd0, mode}, 16'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule